// File: doc/BRIEF.md
# Serial flash fast-read responder

This block plays the memory side of a serial configuration flash for simulation and FPGA prototypes. It only answers the fast-read command. The host lowers chip-select and clocks in four things, most significant bit first: the command byte, a 24-bit start address and one dummy byte. The block then streams stored bytes out on a tri-stateable data pin. It stops only when chip-select returns high. After each byte the read address steps up by one, and it wraps from the top of the array back to zero. One read can therefore circle the whole array for as long as the host keeps clocking.

A synchronous load port fills the small internal array, whose depth is set by a parameter. A busy input stands for an erase, program or write cycle that is in progress. A fast read that arrives while busy is high is refused and produces no output.

The serial clock, chip-select and data input are sampled by the system clock. A serial clock edge counts when the sampled level differs from the level sampled one system clock earlier.

Top module: `sfr_fast_read`

## Requirements
- R1: After reset, and at any time chip-select is high, `dataOe` is 0 and `dataOut` is high impedance.
- R2: While chip-select is low, the first 8 bits sampled on rising serial-clock edges form the command, MSB first. Only the value 8'h0B starts a read. Any other value keeps `dataOe` at 0 until chip-select goes high.
- R3: After the command, 24 address bits (MSB first) and then 8 dummy bits are sampled on rising edges. Only the low `ADDR_W` address bits select the start byte, and the upper bits are ignored.
- R4: Data bits are driven one per falling serial-clock edge, MSB first. The first bit is driven on the falling edge that follows the last dummy bit. `dataOut` and `dataOe` change at the same system-clock edge that sees the serial clock sampled low after being sampled high.
- R5: After all 8 bits of a byte have been driven, the read address increments by one. It wraps from `2**ADDR_W-1` to 0, and streaming continues without a new command.
- R6: If `busy` is 1 on the rising edge that carries the last command bit, the read is refused. `dataOe` stays 0 for the rest of the transaction.
- R7: A rise of chip-select ends the transaction at once and clears all progress. Serial-clock edges while chip-select is high are ignored, so the next transaction always begins with a command byte.
- R8: When `loadEn` is 1 at a system-clock edge, `loadData` is written to the array at `loadAddr`. A later read of that address returns the new value.
- R9: During the command, address and dummy phases, `dataOe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every other input |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command/address input |
| busy | input | 1 | High while an erase, program or write cycle runs |
| loadEn | input | 1 | Array write strobe |
| loadAddr | input | ADDR_W | Array write address |
| loadData | input | 8 | Array write byte |
| dataOut | output | 1 | Serial data out, high impedance when not driving |
| dataOe | output | 1 | High while `dataOut` is driven |

## Verification
Each serial input bit is taken at the system-clock edge that sees the serial clock sampled high after being sampled low. Each output bit appears at the edge that sees the serial clock sampled low after being sampled high, so both results are due zero cycles after the sampled edge and visible one system clock after the stimulus changed. The bench's reference model updates at the same system-clock edges as the design, using the same sampled input levels. Outputs are compared at every falling system-clock edge, half a period after any update. Byte-level checks read each output bit just before the rise that follows it, at least four system clocks after the falling edge that drove it.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int CMD_BITS   = 8;
  localparam int ADDR_FIELD = 24;
  localparam int DUMMY_LEN  = 8;
  localparam int CNT_W      = $clog2(ADDR_FIELD + 1);
  localparam logic [7:0] FAST_READ_OP = 8'h0B;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_REFUSE
  } phase_t;

  typedef struct packed {
    logic clear;     // chip-select high: drop output, rewind
    logic shiftIn;   // take sdi into the shift register
    logic takeAddr;  // last address bit: load the read address
    logic drive;     // falling serial edge in data phase
  } strobe_t;
endpackage

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    busy,
  input  logic    opHit,
  output strobe_t st
);
  logic             sclkPrev;
  logic             rise;
  logic             fall;
  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             lastCmd;
  logic             lastAddr;
  logic             lastDummy;

  assign rise      = sclk & ~sclkPrev;
  assign fall      = ~sclk & sclkPrev;
  assign lastCmd   = (bitCnt == CNT_W'(CMD_BITS - 1));
  assign lastAddr  = (bitCnt == CNT_W'(ADDR_FIELD - 1));
  assign lastDummy = (bitCnt == CNT_W'(DUMMY_LEN - 1));

  always_comb begin
    st          = '0;
    st.clear    = csN;
    st.shiftIn  = !csN && rise &&
                  (phase == PH_CMD || phase == PH_ADDR || phase == PH_DUMMY);
    st.takeAddr = !csN && rise && phase == PH_ADDR && lastAddr;
    st.drive    = !csN && fall && phase == PH_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      phase    <= PH_CMD;
      bitCnt   <= '0;
    end else begin
      sclkPrev <= sclk;
      if (csN) begin
        phase  <= PH_CMD;
        bitCnt <= '0;
      end else if (rise) begin
        unique case (phase)
          PH_CMD: begin
            if (lastCmd) begin
              bitCnt <= '0;
              phase  <= (opHit && !busy) ? PH_ADDR : PH_REFUSE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_ADDR: begin
            if (lastAddr) begin
              bitCnt <= '0;
              phase  <= PH_DUMMY;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (lastDummy) begin
              bitCnt <= '0;
              phase  <= PH_DATA;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: busy at the final command bit must refuse the read
  assert_busy_refuse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rise && phase == PH_CMD && lastCmd && busy) |=> phase == PH_REFUSE);

  // R2: a wrong opcode never reaches the address phase
  assert_bad_op_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rise && phase == PH_CMD && lastCmd && !opHit) |=> phase != PH_ADDR);

  // R3: the bit counter stays inside the longest field
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(ADDR_FIELD - 1));

  // R7: chip-select high rewinds to the command phase
  assert_cs_rewind_R7: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (phase == PH_CMD && bitCnt == '0));
endmodule

// File: rtl/sfr_dpath.sv
module sfr_dpath
  import sfr_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              sdi,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output logic              opHit,
  output logic              outBit,
  output logic              outEn
);
  logic [7:0]            mem [DEPTH];
  logic [ADDR_FIELD-2:0] shiftReg;
  logic [ADDR_FIELD-1:0] capture;
  logic [ADDR_W-1:0]     rdAddr;
  logic [2:0]            bitIdx;

  assign capture = {shiftReg, sdi};
  assign opHit   = (capture[CMD_BITS-1:0] == FAST_READ_OP);

  always_ff @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rdAddr   <= '0;
      bitIdx   <= 3'd7;
      outBit   <= 1'b0;
      outEn    <= 1'b0;
    end else begin
      if (st.shiftIn) shiftReg <= capture[ADDR_FIELD-2:0];
      if (st.clear) begin
        bitIdx <= 3'd7;
        outEn  <= 1'b0;
      end else if (st.takeAddr) begin
        rdAddr <= ADDR_W'(capture);
        bitIdx <= 3'd7;
      end else if (st.drive) begin
        outBit <= mem[rdAddr][bitIdx];
        outEn  <= 1'b1;
        bitIdx <= bitIdx - 1'b1;
        if (bitIdx == 3'd0) rdAddr <= rdAddr + 1'b1;
      end
    end
  end

  // R5: after the last bit of a byte the address advances, wrapping at the top
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.drive && !st.clear && bitIdx == 3'd0) |=> rdAddr == $past(rdAddr) + 1'b1);

  // R9: output enable turns on only from a data-phase falling edge
  assert_oe_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEn) |-> $past(st.drive));
endmodule

// File: rtl/sfr_fast_read.sv
module sfr_fast_read
  import sfr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              busy,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output logic              dataOut,
  output logic              dataOe
);
  strobe_t st;
  logic    opHit;
  logic    outBit;

  sfr_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sclk  (sclk),
    .busy  (busy),
    .opHit (opHit),
    .st    (st)
  );

  sfr_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .sdi      (sdi),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .opHit    (opHit),
    .outBit   (outBit),
    .outEn    (dataOe)
  );

  assign dataOut = dataOe ? outBit : 1'bz;

  // R1/R7: raising chip-select releases the pin on the next edge
  assert_cs_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !dataOe);
endmodule

// File: tb/sim_sfr_fast_read.sv
module sim_sfr_fast_read;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0, busy = 1'b0;
  logic loadEn = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  wire dataOut;
  wire dataOe;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  sfr_fast_read #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .busy(busy),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  // ---------------- behavioural reference ----------------
  int  refMem [DEPTH];
  bit  rxBits[$];
  bit  prevClk;
  bit  refused;
  int  refAddr;
  int  bitPos;
  bit  expOe;
  bit  expBit;

  function automatic int bitsValue(int from, int count);
    int v = 0;
    for (int i = 0; i < count; i++) v = (v << 1) | int'(rxBits[from + i]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      rxBits.delete(); prevClk = 0; expOe = 0; bitPos = 0; refused = 0;
    end else begin
      if (loadEn) refMem[int'(loadAddr)] = int'(loadData);
      if (csN) begin
        rxBits.delete(); expOe = 0; bitPos = 0; refused = 0;
      end else begin
        if (sclk && !prevClk && rxBits.size() < 40) begin
          rxBits.push_back(sdi);
          if (rxBits.size() == 8)
            refused = (bitsValue(0, 8) != 8'h0B) || busy;
          if (rxBits.size() == 32)
            refAddr = bitsValue(8, 24) % DEPTH;
          bitPos = 0;
        end
        if (!sclk && prevClk && rxBits.size() == 40 && !refused) begin
          expBit = refMem[refAddr][7 - bitPos];
          expOe = 1;
          bitPos++;
          if (bitPos == 8) begin
            bitPos = 0;
            refAddr = (refAddr + 1) % DEPTH;
          end
        end
      end
      prevClk = sclk;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      total++;
      if (dataOe !== expOe || (expOe && dataOut !== expBit)) begin
        bad++;
        $display("FAIL %s cycle compare: oe=%b bit=%b expected oe=%b bit=%b",
                 curReq, dataOe, dataOut, expOe, expBit);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int actual, int expected, string what);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  task automatic sendByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdi = b[i];
      waitClk(HALF); sclk = 1'b1;
      waitClk(HALF); sclk = 1'b0;
    end
  endtask

  task automatic readByte(output logic [7:0] b);
    sdi = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitClk(HALF);
      b[i] = dataOut;
      sclk = 1'b1;
      waitClk(HALF); sclk = 1'b0;
    end
  endtask

  task automatic startRead(logic [7:0] op, logic [23:0] a);
    csN = 1'b0; waitClk(2);
    sendByte(op);
    sendByte(a[23:16]); sendByte(a[15:8]); sendByte(a[7:0]);
  endtask

  task automatic endRead();
    waitClk(2); csN = 1'b1; waitClk(3);
  endtask

  function automatic int pattern(int i);
    return (i * 7 + 3) & 8'hFF;
  endfunction

  // ---------------- sequence ----------------
  logic [7:0] got;

  initial begin : main
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    check("R1", int'(dataOe), 0, "oe after reset");

    curReq = "R8";
    for (int i = 0; i < DEPTH; i++) begin
      loadEn = 1'b1; loadAddr = ADDR_W'(i); loadData = 8'(pattern(i));
      waitClk(1);
    end
    loadEn = 1'b0;
    waitClk(2);

    // R2/R4: plain read of three bytes
    curReq = "R4";
    startRead(8'h0B, 24'h000010);
    check("R9", int'(dataOe), 0, "oe during address phase");
    sendByte(8'hA5);
    for (int k = 0; k < 3; k++) begin
      readByte(got);
      check("R4", int'(got), pattern(16 + k), "streamed byte");
    end
    endRead();
    check("R1", int'(dataOe), 0, "oe after cs high");

    // R3: upper address bits ignored
    curReq = "R3";
    startRead(8'h0B, 24'hFFFF05);
    sendByte(8'h00);
    readByte(got);
    check("R3", int'(got), pattern(5), "byte at masked address");
    endRead();

    // R5: wrap from the top address
    curReq = "R5";
    startRead(8'h0B, 24'h0000FE);
    sendByte(8'h00);
    for (int k = 0; k < 4; k++) begin
      readByte(got);
      check("R5", int'(got), pattern((254 + k) % DEPTH), "byte across wrap");
    end
    endRead();

    // R2: wrong opcode gives no output
    curReq = "R2";
    startRead(8'h03, 24'h000010);
    sendByte(8'h00);
    readByte(got);
    check("R2", int'(dataOe), 0, "oe after wrong opcode");
    endRead();

    // R6: busy at the last command bit refuses the read
    curReq = "R6";
    busy = 1'b1;
    csN = 1'b0; waitClk(2);
    sendByte(8'h0B);
    busy = 1'b0;
    sendByte(8'h00); sendByte(8'h00); sendByte(8'h20);
    sendByte(8'h00);
    readByte(got);
    check("R6", int'(dataOe), 0, "oe on refused read");
    endRead();

    // R7: abort mid address, toggle sclk while deselected, then read again
    curReq = "R7";
    csN = 1'b0; waitClk(2);
    sendByte(8'h0B);
    sendByte(8'h00);
    sdi = 1'b1; waitClk(HALF); sclk = 1'b1; waitClk(HALF); sclk = 1'b0;
    endRead();
    for (int k = 0; k < 5; k++) begin
      sdi = 1'b1; waitClk(HALF); sclk = 1'b1; waitClk(HALF); sclk = 1'b0;
    end
    startRead(8'h0B, 24'h000040);
    sendByte(8'h00);
    readByte(got);
    check("R7", int'(got), pattern(64), "read after abort");
    readByte(got);
    check("R7", int'(got), pattern(65), "second byte after abort");
    waitClk(1);
    csN = 1'b1; waitClk(2);
    check("R7", int'(dataOe), 0, "oe released mid byte");
    waitClk(2);

    // R8: reload one byte and read it back
    curReq = "R8";
    loadEn = 1'b1; loadAddr = 8'h33; loadData = 8'h5A; waitClk(1);
    loadEn = 1'b0; waitClk(2);
    startRead(8'h0B, 24'h000033);
    sendByte(8'hFF);
    readByte(got);
    check("R8", int'(got), 8'h5A, "reloaded byte");
    endRead();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule